// File: doc/BRIEF.md
# 16-bit Error Detection and Correction Unit

This block protects a 16-bit data word with an 8-bit check byte. On the write side it forms the check byte from the data word with no clock delay, so the byte can be stored next to the word. On the read side it takes a stored word and its stored check byte and forms the check byte again from the word. The XOR of the two bytes is an 8-bit syndrome. The unit decodes the syndrome and returns a result one clock later. The result holds the data word, the syndrome and two active-low flags: one for an error that can be corrected and one for an error that cannot.

A mode input sets how a correctable error is handled. In correct mode, a syndrome that points at a data bit inverts that bit on the output. In detect mode the flags are still reported, but the word passes through unchanged. Detect mode exists because three flipped bits can produce the syndrome of a single data bit, and correcting on that syndrome adds another error.

The read path is a one-deep stream stage with valid/ready on both sides. A word is taken in on a clock edge where `rd_valid` and `rd_ready` are both high. `rd_ready` is high when the output register is empty or is being emptied in the same cycle, so a consumer that holds `out_ready` low stalls the producer. A result stays unchanged on the output until `out_ready` takes it. The mode input is sampled together with the word.

Top module: `edac16_core`

## Requirements
- R1: `wr_check` is combinational in `wr_data`. Bits 7 and 6 are always 0. Bit j (0..5) is the XOR of every data bit whose single-error syndrome (see R4) has bit j set.
- R2: `out_syndrome` equals `rd_check` XOR the check byte that R1 forms from `rd_data`, for the word accepted on the previous handshake.
- R3: A zero syndrome leaves `out_cerr_n` and `out_ncerr_n` both high and `out_data` equal to the accepted word.
- R4: The single-error syndrome of data bit i is, for i = 15 down to 0: 34h, 2Ah, 29h, 25h, 32h, 1Ah, 16h, 13h, 31h, 23h, 15h, 0Bh, 2Ch, 1Ch, 0Eh, 0Dh. When the syndrome equals one of these entries, `out_cerr_n` goes low. With `corr_en`=1 the indicated bit of `out_data` is inverted.
- R5: A syndrome with exactly one bit set (a single check-bit error, 01h to 80h) drives `out_cerr_n` low and leaves `out_data` equal to the accepted word.
- R6: Any other nonzero syndrome drives `out_ncerr_n` low, keeps `out_cerr_n` high and leaves the word unchanged. The two flags are never low together.
- R7: With `corr_en`=0 the flags and syndrome are the same as in correct mode, but `out_data` always equals the accepted word. For example, errors in data bits 0 and 9 plus check bit 0 give 1Ah. In correct mode that syndrome inverts bit 10; in detect mode it does not.
- R8: A word is accepted on an edge where `rd_valid` and `rd_ready` are both high. `rd_ready` = !`out_valid` || `out_ready`. `out_valid` is high in the cycle after an accept. All outputs stay unchanged while `out_valid` is high and `out_ready` is low.
- R9: A synchronous reset sets `out_valid` low, `out_data` and `out_syndrome` to zero, and both flags high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_data | input | 16 | Word to be written |
| wr_check | output | 8 | Check byte for `wr_data` |
| rd_valid | input | 1 | Read word valid |
| rd_ready | output | 1 | Unit can accept a read word |
| rd_data | input | 16 | Stored data word |
| rd_check | input | 8 | Stored check byte |
| corr_en | input | 1 | 1 = correct mode, 0 = detect mode |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Corrected or passed-through word |
| out_syndrome | output | 8 | Syndrome of the word |
| out_cerr_n | output | 1 | Correctable error, active low |
| out_ncerr_n | output | 1 | Non-correctable error, active low |

## Verification
Two things can happen on the same edge: a new word is accepted while the previous result is being taken by the consumer. The bench provokes this by driving words back to back while `out_ready` is toggled at random. A scoreboard in acceptance order then confirms that no result is lost, duplicated or altered while stalled. The second overlap is between correction and error flagging. A corrupted word carries both a flag and a possible bit inversion in one result, and the bench judges the pair against its own syndrome model in both modes. The 1Ah triple-error alias is included in that check.

// File: rtl/edac16_pkg.sv
package edac16_pkg;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int GW = 6;

  typedef logic [CW-1:0] syn_t;

  typedef enum logic [1:0] {
    CLS_CLEAN = 2'd0,
    CLS_DATA  = 2'd1,
    CLS_CHECK = 2'd2,
    CLS_FATAL = 2'd3
  } err_class_e;

  // single-error syndrome of data bit i
  function automatic syn_t data_syn(input int i);
    case (i)
      15: data_syn = 8'h34;
      14: data_syn = 8'h2A;
      13: data_syn = 8'h29;
      12: data_syn = 8'h25;
      11: data_syn = 8'h32;
      10: data_syn = 8'h1A;
      9:  data_syn = 8'h16;
      8:  data_syn = 8'h13;
      7:  data_syn = 8'h31;
      6:  data_syn = 8'h23;
      5:  data_syn = 8'h15;
      4:  data_syn = 8'h0B;
      3:  data_syn = 8'h2C;
      2:  data_syn = 8'h1C;
      1:  data_syn = 8'h0E;
      default: data_syn = 8'h0D;
    endcase
  endfunction
endpackage

// File: rtl/edac16_checkgen.sv
module edac16_checkgen
  import edac16_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int CHK_W  = CW,
  parameter int GEN_W  = GW
) (
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  check
);
  localparam int PAD_W = CHK_W - GEN_W;

  logic [GEN_W-1:0] par;

  always_comb begin
    par = '0;
    for (int i = 0; i < DATA_W; i++) begin
      syn_t col;
      col = data_syn(i);
      for (int j = 0; j < GEN_W; j++) begin
        if (col[j]) par[j] = par[j] ^ data[i];
      end
    end
  end

  assign check = {{PAD_W{1'b0}}, par};
endmodule

// File: rtl/edac16_decode.sv
module edac16_decode
  import edac16_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int CHK_W  = CW
) (
  input  logic [CHK_W-1:0]  syn,
  output logic [DATA_W-1:0] flip,
  output err_class_e        cls
);
  logic [DATA_W-1:0] hit;
  logic              one_hot;

  for (genvar g = 0; g < DATA_W; g++) begin : g_match
    assign hit[g] = (syn == data_syn(g));
  end

  assign one_hot = (syn != '0) && ((syn & (syn - 1'b1)) == '0);
  assign flip    = hit;

  always_comb begin
    if (syn == '0)      cls = CLS_CLEAN;
    else if (|hit)      cls = CLS_DATA;
    else if (one_hot)   cls = CLS_CHECK;
    else                cls = CLS_FATAL;
  end
endmodule

// File: rtl/edac16_core.sv
module edac16_core
  import edac16_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int CHK_W  = CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CHK_W-1:0]  wr_check,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CHK_W-1:0]  rd_check,
  input  logic              corr_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CHK_W-1:0]  out_syndrome,
  output logic              out_cerr_n,
  output logic              out_ncerr_n
);
  logic [CHK_W-1:0]  regen;
  logic [CHK_W-1:0]  syn;
  logic [DATA_W-1:0] flip;
  logic [DATA_W-1:0] fixed;
  err_class_e        cls;
  logic              accept;

  edac16_checkgen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_wr_gen (
    .data (wr_data),
    .check(wr_check)
  );

  edac16_checkgen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_rd_gen (
    .data (rd_data),
    .check(regen)
  );

  assign syn = rd_check ^ regen;

  edac16_decode #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
    .syn (syn),
    .flip(flip),
    .cls (cls)
  );

  assign fixed    = (corr_en && cls == CLS_DATA) ? (rd_data ^ flip) : rd_data;
  assign rd_ready = !out_valid || out_ready;
  assign accept   = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_syndrome <= '0;
      out_cerr_n   <= 1'b1;
      out_ncerr_n  <= 1'b1;
    end else if (accept) begin
      out_valid    <= 1'b1;
      out_data     <= fixed;
      out_syndrome <= syn;
      out_cerr_n   <= !(cls == CLS_DATA || cls == CLS_CHECK);
      out_ncerr_n  <= !(cls == CLS_FATAL);
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  // R6
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_cerr_n || out_ncerr_n));

  // R3
  clean_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_syndrome == '0) |-> (out_cerr_n && out_ncerr_n));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_syndrome) && $stable(out_cerr_n) && $stable(out_ncerr_n)));

  // R8
  accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready) |=> out_valid);

  // R7
  detect_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready && !corr_en) |=> (out_data == $past(rd_data)));

  // R6
  fatal_no_fix_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready && cls == CLS_FATAL) |=> (out_data == $past(rd_data)));
endmodule

// File: tb/edac16_core_test.sv
module edac16_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] wr_data = '0;
  logic [7:0]  wr_check;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [15:0] rd_data = '0;
  logic [7:0]  rd_check = '0;
  logic        corr_en = 1'b1;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic [7:0]  out_syndrome;
  logic        out_cerr_n;
  logic        out_ncerr_n;

  int checks = 0;
  int fails  = 0;
  bit random_ready = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] data;
    logic [7:0]  syn;
    logic        cerr_n;
    logic        ncerr_n;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  edac16_core uut (
    .clk(clk), .rst(rst), .wr_data(wr_data), .wr_check(wr_check),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_check(rd_check), .corr_en(corr_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_syndrome(out_syndrome),
    .out_cerr_n(out_cerr_n), .out_ncerr_n(out_ncerr_n)
  );

  function automatic logic [7:0] tsyn(input int i);
    logic [7:0] t [16] = '{8'h0D, 8'h0E, 8'h1C, 8'h2C, 8'h0B, 8'h15, 8'h23, 8'h31,
                           8'h13, 8'h16, 8'h1A, 8'h32, 8'h25, 8'h29, 8'h2A, 8'h34};
    return t[i];
  endfunction

  function automatic logic [7:0] enc(input logic [15:0] d);
    logic [7:0] c = '0;
    for (int j = 0; j < 6; j++)
      for (int i = 0; i < 16; i++)
        if (tsyn(i)[j]) c[j] = c[j] ^ d[i];
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  // errmask: bits 15:0 data, 23:16 check byte
  task automatic send(input logic [15:0] d, input logic [23:0] errmask,
                      input bit mode, input string tag);
    exp_t e;
    logic [7:0] s = '0;
    int   hitbit = -1;
    logic [7:0] good;
    bit   took;
    for (int i = 0; i < 16; i++) if (errmask[i]) s = s ^ tsyn(i);
    s = s ^ errmask[23:16];
    for (int i = 0; i < 16; i++) if (s == tsyn(i)) hitbit = i;
    e.data = d ^ errmask[15:0];
    e.syn = s;
    e.cerr_n = 1'b1;
    e.ncerr_n = 1'b1;
    e.tag = tag;
    if (s != 0) begin
      if (hitbit >= 0) begin
        e.cerr_n = 1'b0;
        if (mode) e.data[hitbit] = ~e.data[hitbit];
      end else if ($countones(s) == 1) e.cerr_n = 1'b0;
      else e.ncerr_n = 1'b0;
    end
    @(negedge clk);
    wr_data = d;
    good = enc(d);
    #1;
    check(wr_check == good, "R1", $sformatf("wr_check act=%h exp=%h", wr_check, good));
    rd_data  = d ^ errmask[15:0];
    rd_check = good ^ errmask[23:16];
    corr_en  = mode;
    rd_valid = 1'b1;
    forever begin
      #1;
      took = rd_ready;
      @(posedge clk);
      if (took) break;
      @(negedge clk);
    end
    sb.push_back(e);
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  // monitor / scoreboard
  logic        held = 1'b0;
  logic [33:0] hold_v;
  always @(negedge clk) begin
    if (!rst) begin
      if (random_ready) out_ready = ($urandom_range(0, 2) != 0);
      else out_ready = 1'b1;
      #1;
      if (held)
        check(out_valid && hold_v == {out_data, out_syndrome, out_cerr_n, out_ncerr_n},
              "R8", $sformatf("stall act=%h exp=%h",
                              {out_data, out_syndrome, out_cerr_n, out_ncerr_n}, hold_v));
      held = out_valid && !out_ready;
      hold_v = {out_data, out_syndrome, out_cerr_n, out_ncerr_n};
      if (out_valid && out_ready) begin
        if (sb.size() == 0) check(1'b0, "R8", "act=result exp=none");
        else begin
          exp_t e;
          e = sb.pop_front();
          check(out_data == e.data && out_syndrome == e.syn &&
                out_cerr_n == e.cerr_n && out_ncerr_n == e.ncerr_n, e.tag,
                $sformatf("act=%h/%h/%b%b exp=%h/%h/%b%b", out_data, out_syndrome,
                          out_cerr_n, out_ncerr_n, e.data, e.syn, e.cerr_n, e.ncerr_n));
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      check(1'b0, "WATCHDOG", "act=timeout exp=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R9 reset state
    check(!out_valid && out_data == 0 && out_syndrome == 0 && out_cerr_n && out_ncerr_n,
          "R9", $sformatf("act=%b/%h/%h/%b%b exp=0/0000/00/11", out_valid, out_data,
                          out_syndrome, out_cerr_n, out_ncerr_n));
    // R3 clean words, R2 syndrome
    send(16'h0000, 24'h0, 1'b1, "R3");
    send(16'hFFFF, 24'h0, 1'b1, "R3");
    send(16'hA5C3, 24'h0, 1'b0, "R2");
    // R4 every data bit, correct mode and detect mode (R7)
    for (int i = 0; i < 16; i++) send(16'($urandom), 24'(1) << i, 1'b1, "R4");
    for (int i = 0; i < 16; i++) send(16'($urandom), 24'(1) << i, 1'b0, "R7");
    // R5 every check bit, including bit 7 (80h)
    for (int k = 0; k < 8; k++) send(16'($urandom), 24'(1) << (16 + k), 1'b1, "R5");
    // R7 triple-error alias 1Ah: data 0, data 9, check 0
    send(16'h1234, 24'h010201, 1'b1, "R7");
    send(16'h1234, 24'h010201, 1'b0, "R7");
    // R6 random double errors, with back-pressure (R8)
    random_ready = 1'b1;
    for (int n = 0; n < 60; n++) begin
      int a = $urandom_range(0, 23);
      int b = $urandom_range(0, 23);
      if (a == b) b = (a + 1) % 24;
      send(16'($urandom), (24'(1) << a) | (24'(1) << b), n[0], "R6");
    end
    // R8 back-to-back with random ready
    for (int n = 0; n < 20; n++) send(16'($urandom), 24'h0, 1'b1, "R8");
    while (sb.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule